// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block sits between a 16-bit processor data bus and a data memory that is organised as two independent 8-bit banks. Each bank carries one extra storage column that holds one parity bit per stored byte. On a write cycle the block computes a parity bit for every byte lane whose byte enable is set. It presents that bit on the lane's parity write-data output and raises the matching parity write strobe, so a single-byte write touches only its own lane's parity column.

On a read, the memory returns both data bytes and both stored parity bits. At the clock edge that closes the read data phase, the block recomputes parity over every enabled lane together with its stored bit. It then registers an active-low error flag for the processor and a per-lane error vector. A static configuration input chooses even or odd parity, and the same choice governs both generation and checking. The lane width and the number of lanes are parameters. The defaults give two 8-bit lanes.

Top module: `bytelane_parity`

## Requirements
- R1: While a write is active (`wr_en`=1), `par_wdata[i]` makes the lane's data byte plus that bit have an even count of ones when `cfg_odd`=0 and an odd count when `cfg_odd`=1.
- R2: `par_we[i]` is 1 exactly when `wr_en`=1 and `wr_be[i]`=1. With `wr_en`=0, no parity strobe is raised.
- R3: Lane 0 is data bits 7:0 and lane 1 is bits 15:8. Enable and parity bit i always belong to lane i. For an all-zero byte, the generated bit is 0 in even mode and 1 in odd mode.
- R4: At a clock edge with `rd_done`=1, an enabled lane is in error when the count of ones over its byte and its stored bit `rd_par[i]` is odd in even mode, or even in odd mode.
- R5: After such an edge, `err_lane[i]` is 1 for each enabled lane in error. `pe_n` is 0 if any bit of `err_lane` is set and 1 otherwise.
- R6: `pe_n` and `err_lane` keep their value at every edge without `rd_done`, including edges that carry writes.
- R7: A synchronous active-high `rst` sets `pe_n` to 1 and `err_lane` to 0.
- R8: A read completing with no error on any enabled lane returns `pe_n` to 1 and clears `err_lane`, whatever the earlier result was.
- R9: A lane whose `rd_be` bit is 0 at the read edge is not checked. A corrupt byte or parity bit on that lane leaves `pe_n` at 1 and its `err_lane` bit at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_odd | input | 1 | Parity sense: 0 even, 1 odd |
| wr_en | input | 1 | Write cycle in progress |
| wr_be | input | 2 | Write byte enables, bit i for lane i |
| wr_data | input | 16 | Write data from the processor |
| par_wdata | output | 2 | Generated parity bit for each lane's parity column |
| par_we | output | 2 | Write strobe for each lane's parity column |
| rd_done | input | 1 | The read data phase ends at this clock edge |
| rd_be | input | 2 | Read byte enables, bit i for lane i |
| rd_data | input | 16 | Data returned by the memory banks |
| rd_par | input | 2 | Parity bits returned by the parity columns |
| pe_n | output | 1 | Registered parity error flag, active low |
| err_lane | output | 2 | Registered per-lane error, bit i for lane i |

## Verification
Parity generation for a write and the checking of a read that ends can happen in the same clock cycle, because the write path and the read path are separate. The bench provokes this by driving a write to one location while a read of another location, holding an injected bit flip, ends on that same edge. It then judges both results against values computed in the bench: the parity bits and strobes presented for the write must be correct, and the flag and lane vector must reflect only the read. Single-bit flips are injected into stored data bits and into stored parity bits in both polarities. Each expected result is computed by bench functions from the requirements.

// File: rtl/bytelane_parity_pkg.sv
package bytelane_parity_pkg;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_mode_e;

    typedef struct packed {
        logic checked;
        logic bad;
    } lane_verdict_t;

    localparam int unsigned FOLD_W = 64;

    function automatic logic fold_parity(input logic [FOLD_W-1:0] vec,
                                         input par_mode_e mode);
        logic acc;
        acc = ^vec;
        return acc ^ logic'(mode);
    endfunction

endpackage

// File: rtl/bytelane_par_gen.sv
module bytelane_par_gen
    import bytelane_parity_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_data,
    input  par_mode_e         mode,
    output logic              par_bit
);
    always_comb begin
        par_bit = fold_parity(FOLD_W'(lane_data), mode);
    end
endmodule

// File: rtl/bytelane_par_chk.sv
module bytelane_par_chk
    import bytelane_parity_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_data,
    input  logic              stored_par,
    input  logic              lane_en,
    input  par_mode_e         mode,
    output lane_verdict_t     verdict
);
    logic expect_bit;

    always_comb begin
        expect_bit      = fold_parity(FOLD_W'(lane_data), mode);
        verdict.checked = lane_en;
        verdict.bad     = lane_en & (expect_bit ^ stored_par);
    end
endmodule

// File: rtl/bytelane_err_reg.sv
module bytelane_err_reg
    import bytelane_parity_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  lane_verdict_t [LANES-1:0] verdicts,
    output logic                 flag_n,
    output logic [LANES-1:0]     lane_bad
);
    logic [LANES-1:0] bad_vec;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            bad_vec[i] = verdicts[i].checked & verdicts[i].bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_n   <= 1'b1;
            lane_bad <= '0;
        end else if (capture) begin
            flag_n   <= ~(|bad_vec);
            lane_bad <= bad_vec;
        end
    end
endmodule

// File: rtl/bytelane_parity.sv
module bytelane_parity
    import bytelane_parity_pkg::*;
#(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_odd,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_be,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    output logic [LANES-1:0]          par_wdata,
    output logic [LANES-1:0]          par_we,
    input  logic                      rd_done,
    input  logic [LANES-1:0]          rd_be,
    input  logic [LANES*LANE_W-1:0]   rd_data,
    input  logic [LANES-1:0]          rd_par,
    output logic                      pe_n,
    output logic [LANES-1:0]          err_lane
);
    localparam int unsigned BUS_W = LANES * LANE_W;

    par_mode_e                 mode;
    lane_verdict_t [LANES-1:0] verdicts;
    logic [BUS_W-1:0]          wr_bus;
    logic [BUS_W-1:0]          rd_bus;

    assign mode   = par_mode_e'(cfg_odd);
    assign wr_bus = wr_data;
    assign rd_bus = rd_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bytelane_par_gen #(.LANE_W(LANE_W)) u_gen (
            .lane_data (wr_bus[g*LANE_W +: LANE_W]),
            .mode      (mode),
            .par_bit   (par_wdata[g])
        );

        assign par_we[g] = wr_en & wr_be[g];

        bytelane_par_chk #(.LANE_W(LANE_W)) u_chk (
            .lane_data  (rd_bus[g*LANE_W +: LANE_W]),
            .stored_par (rd_par[g]),
            .lane_en    (rd_be[g]),
            .mode       (mode),
            .verdict    (verdicts[g])
        );
    end

    bytelane_err_reg #(.LANES(LANES)) u_err (
        .clk      (clk),
        .rst      (rst),
        .capture  (rd_done),
        .verdicts (verdicts),
        .flag_n   (pe_n),
        .lane_bad (err_lane)
    );
endmodule

// File: rtl/bytelane_parity_chk.sv
module bytelane_parity_chk #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_odd,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        par_wdata,
    input  logic [LANES-1:0]        par_we,
    input  logic                    rd_done,
    input  logic [LANES-1:0]        rd_be,
    input  logic [LANES*LANE_W-1:0] rd_data,
    input  logic [LANES-1:0]        rd_par,
    input  logic                    pe_n,
    input  logic [LANES-1:0]        err_lane
);
    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (pe_n && err_lane == '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_done |=> ($stable(pe_n) && $stable(err_lane)));

    a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (par_we == '0));

    a_r9_no_lane_checked: assert property (@(posedge clk) disable iff (rst)
        (rd_done && rd_be == '0) |=> (pe_n && err_lane == '0));

    a_r5_lane_subset: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> ((err_lane & ~$past(rd_be)) == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        a_r1_gen_sense: assert property (@(posedge clk) disable iff (rst)
            par_we[g] |->
            (((^wr_data[g*LANE_W +: LANE_W]) ^ par_wdata[g]) == cfg_odd));

        a_r4_lane_error: assert property (@(posedge clk) disable iff (rst)
            (rd_done && rd_be[g] &&
             (((^rd_data[g*LANE_W +: LANE_W]) ^ rd_par[g]) != cfg_odd))
            |=> (err_lane[g] && !pe_n));
    end
endmodule

bind bytelane_parity bytelane_parity_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_parity_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_odd   (cfg_odd),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .par_wdata (par_wdata),
    .par_we    (par_we),
    .rd_done   (rd_done),
    .rd_be     (rd_be),
    .rd_data   (rd_data),
    .rd_par    (rd_par),
    .pe_n      (pe_n),
    .err_lane  (err_lane)
);

// File: tb/bytelane_parity_bench.sv
`timescale 1ns/1ps
module bytelane_parity_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_odd;
    logic        wr_en;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;
    logic [1:0]  par_wdata;
    logic [1:0]  par_we;
    logic        rd_done;
    logic [1:0]  rd_be;
    logic [15:0] rd_data;
    logic [1:0]  rd_par;
    logic        pe_n;
    logic [1:0]  err_lane;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [15:0] mem_d [16];
    logic [1:0]  mem_p [16];

    always #4 clk = ~clk;

    bytelane_parity u_bytelane_parity (
        .clk(clk), .rst(rst), .cfg_odd(cfg_odd),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .par_wdata(par_wdata), .par_we(par_we),
        .rd_done(rd_done), .rd_be(rd_be), .rd_data(rd_data), .rd_par(rd_par),
        .pe_n(pe_n), .err_lane(err_lane)
    );

    function automatic logic exp_bit(input logic [7:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction

    function automatic logic [1:0] exp_err(input logic [15:0] d, input logic [1:0] p,
                                           input logic [1:0] be, input logic odd);
        logic [1:0] e;
        e[0] = be[0] & (exp_bit(d[7:0], odd)  != p[0]);
        e[1] = be[1] & (exp_bit(d[15:8], odd) != p[1]);
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive a write at negedge, check the generated bits mid-cycle, store them
    task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        #1;
        chk("R2 strobes", par_we, be);
        for (int i = 0; i < 2; i++) begin
            if (be[i]) chk("R1 R3 parity bit", par_wdata[i], exp_bit(d[i*8 +: 8], cfg_odd));
        end
        for (int i = 0; i < 2; i++) begin
            if (par_we[i]) begin
                mem_d[a][i*8 +: 8] = d[i*8 +: 8];
                mem_p[a][i] = par_wdata[i];
            end
        end
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    // read with optional injected flips; result checked on the following negedge
    task automatic do_read(input int a, input logic [1:0] be,
                           input logic [15:0] fd, input logic [1:0] fp, input string req);
        logic [1:0] e;
        @(negedge clk);
        rd_done = 1'b1; rd_be = be;
        rd_data = mem_d[a] ^ fd; rd_par = mem_p[a] ^ fp;
        e = exp_err(rd_data, rd_par, be, cfg_odd);
        @(negedge clk);
        rd_done = 1'b0; rd_be = 2'b00;
        chk({req, " err_lane"}, err_lane, e);
        chk({req, " pe_n"}, pe_n, (e == 2'b00));
    endtask

    task automatic idle_hold(input int n, input logic ep, input logic [1:0] el);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = k[0]; wr_be = 2'b11; wr_data = 16'h5a3c;
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 hold pe_n", pe_n, ep);
        chk("R6 hold err_lane", err_lane, el);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cfg_odd = 1'b0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
        rd_done = 1'b0; rd_be = '0; rd_data = '0; rd_par = '0;
        for (int i = 0; i < 16; i++) begin mem_d[i] = '0; mem_p[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R7 reset pe_n", pe_n, 1'b1);
        chk("R7 reset err_lane", err_lane, 2'b00);
        rst = 1'b0;

        for (int pol = 0; pol < 2; pol++) begin
            cfg_odd = pol[0];
            // directed: all-zero bytes give 0 even / 1 odd (R3)
            do_write(0, 16'h0000, 2'b11);
            chk("R3 zero byte lane1", mem_p[0][1], pol[0]);
            // lane-only writes touch only that lane (R2)
            do_write(1, 16'hffff, 2'b11);
            do_write(1, 16'h0001, 2'b01);
            chk("R2 lane1 column kept", mem_p[1][1], exp_bit(8'hff, pol[0]));
            do_read(1, 2'b11, 16'h0, 2'b00, "R8 clean read");
            // data flip lane0 (R4 R5)
            do_read(1, 2'b11, 16'h0004, 2'b00, "R5 data flip lane0");
            idle_hold(4, 1'b0, 2'b01);
            // parity flip lane1
            do_read(0, 2'b11, 16'h0, 2'b10, "R4 parity flip lane1");
            // both lanes
            do_read(0, 2'b11, 16'h0100, 2'b01, "R5 both lanes");
            // unchecked lane ignored
            do_read(0, 2'b10, 16'h0080, 2'b00, "R9 lane0 unchecked");
            do_read(0, 2'b00, 16'h8001, 2'b11, "R9 no lane");
            // clean read clears error
            do_read(0, 2'b01, 16'h0, 2'b01, "R4 parity flip lane0");
            do_read(0, 2'b11, 16'h0, 2'b00, "R8 clear");
            // same-cycle write and read
            @(negedge clk);
            wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h7300;
            rd_done = 1'b1; rd_be = 2'b11; rd_data = mem_d[1] ^ 16'h0200; rd_par = mem_p[1];
            #1;
            chk("R2 same cycle strobe", par_we, 2'b10);
            chk("R1 same cycle bit", par_wdata[1], exp_bit(8'h73, pol[0]));
            @(negedge clk);
            wr_en = 1'b0; rd_done = 1'b0;
            chk("R5 same cycle err_lane", err_lane, 2'b10);
            chk("R5 same cycle pe_n", pe_n, 1'b0);
            // random mix
            for (int n = 0; n < 60; n++) begin
                int a;
                logic [1:0] be;
                logic [15:0] fd;
                logic [1:0] fp;
                a  = int'($urandom_range(15, 2));
                be = 2'($urandom_range(3, 1));
                do_write(a, 16'($urandom), be);
                fd = '0; fp = '0;
                case ($urandom_range(3, 0))
                    0: fd = 16'(1) << $urandom_range(15, 0);
                    1: fp = 2'(1) << $urandom_range(1, 0);
                    default: ;
                endcase
                do_read(a, 2'($urandom_range(3, 0)), fd, fp, "R4 random");
            end
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7 reset after error pe_n", pe_n, 1'b1);
        chk("R7 reset after error err_lane", err_lane, 2'b00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule